// File: doc/BRIEF.md
# Strobe-Handshake Parallel Bus Master

This block carries out one read or one write transfer at a time on a parallel bus. The bus uses an address strobe and two byte-lane data strobes, and the addressed device ends each transfer asynchronously. A request port supplies the address, the direction, the byte-lane selects and the write data. The block then runs the bus through eight half-period phases, S0 to S7, and reports completion with a one-cycle done pulse, an error flag and the captured read data.

The block runs from a clock at twice the bus clock rate, so each phase lasts exactly one cycle. Even phases are the high halves of the bus clock and odd phases are the low halves. A write differs from a read in three ways: the data strobes come on two phases later, the read/write line goes low, and the data-bus driver is enabled. The acknowledge and bus-error inputs pass through a synchroniser and are examined at one point only, the end of S4. If neither input is present there, the block holds the S4 outputs for whole bus-clock periods until one of them arrives.

Top module: `hsbus_master`

## Requirements
- R1: After reset, the block is idle: `idle` is 1, all three strobes are high, `bus_rw` is 1, `bus_data_oe` is 0, and `rsp_done` and `rsp_error` are 0.
- R2: `bus_addr` is 0 in S0, the first cycle after the request is accepted. It carries the latched request address from S1 through S7 and returns to 0 once idle.
- R3: `bus_as_n` goes low in S2, the third cycle after acceptance. It stays low through any wait states, S5 and S6, and is high again in S7.
- R4: `req_lanes[1]` selects `bus_uds_n` and `req_lanes[0]` selects `bus_lds_n`. On a read, the selected strobes are low from S2. On a write, both strobes stay high in S2 and S3, and the selected ones go low from S4. All strobes are high in S7.
- R5: On a write, `bus_rw` is 0 from S2 through S7. On a read, and whenever the block is idle, `bus_rw` is 1.
- R6: On a write, `bus_data_oe` is 1 and `bus_data_out` equals the write data from S3 through S7. On a read, `bus_data_oe` stays 0. The enable is 0 in the cycle that `rsp_done` is high.
- R7: Acknowledge and bus error are looked at only at the end of S4, after a synchroniser of `SYNC_STAGES` flops. A pulse that has cleared before S4 does not advance the transfer.
- R8: If neither input is seen at the end of S4, each wait state adds exactly two cycles. `rsp_done` rises 8 + 2·W cycles after the acceptance edge, where W is the number of wait states.
- R9: On a read, `bus_data_in` is captured at the edge that enters S7 and is presented on `rsp_rdata` while `rsp_done` is high.
- R10: `rsp_done` is a single-cycle pulse. `rsp_error` is 1 with it when bus error was seen at the sampling point. Bus error wins when both inputs are present.
- R11: A request is accepted only while idle. A `req_valid` raised during a transfer starts nothing and does not change the latched address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the bus clock rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Start a transfer (taken only when idle) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Transfer address |
| req_lanes | input | 2 | Byte-lane selects, bit 1 upper, bit 0 lower |
| req_wdata | input | DW | Write data |
| idle | output | 1 | No transfer in progress |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_error | output | 1 | Transfer ended with bus error |
| rsp_rdata | output | DW | Captured read data |
| bus_addr | output | AW | Address outputs |
| bus_as_n | output | 1 | Address strobe, active low |
| bus_uds_n | output | 1 | Upper data strobe, active low |
| bus_lds_n | output | 1 | Lower data strobe, active low |
| bus_rw | output | 1 | 1 = read, 0 = write |
| bus_data_oe | output | 1 | Data-bus output enable |
| bus_data_out | output | DW | Data driven onto the bus |
| bus_data_in | input | DW | Data read from the bus |
| bus_ack_n | input | 1 | Transfer acknowledge, active low, asynchronous |
| bus_berr_n | input | 1 | Bus error, active low, asynchronous |

## Verification
Every bus output has a fixed phase: S0 is the cycle after the accepting edge, and phase k is k cycles later, with each wait state inserting two cycles after S4. The bench's responder asserts its termination input a known number of cycles after the address strobe falls. From that delay and the two synchroniser flops, the bench works out the wait count W. It then checks each strobe, enable and address at the falling edge inside the phase where the value is due, and expects `rsp_done`, `rsp_error` and `rsp_rdata` exactly 8 + 2·W cycles after acceptance.

// File: rtl/hsbus_pkg.sv
package hsbus_pkg;
   typedef enum logic [3:0] {
      ST_IDLE,
      ST_S0,
      ST_S1,
      ST_S2,
      ST_S3,
      ST_S4,
      ST_W4,   // low half of a wait period, outputs as in S4
      ST_S5,
      ST_S6,
      ST_S7
   } phase_e;
endpackage

// File: rtl/hsbus_sync.sv
module hsbus_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("hsbus_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/hsbus_seq.sv
module hsbus_seq
   import hsbus_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  logic   req_valid,
   input  logic   ack_s,
   input  logic   berr_s,
   output phase_e state,
   output logic   accept,
   output logic   done,
   output logic   error
);
   phase_e nxt;
   logic   berr_seen;

   assign accept = (state == ST_IDLE) && req_valid;

   always_comb begin
      nxt = state;
      unique case (state)
         ST_IDLE: nxt = req_valid ? ST_S0 : ST_IDLE;
         ST_S0:   nxt = ST_S1;
         ST_S1:   nxt = ST_S2;
         ST_S2:   nxt = ST_S3;
         ST_S3:   nxt = ST_S4;
         ST_S4:   nxt = (ack_s || berr_s) ? ST_S5 : ST_W4;
         ST_W4:   nxt = ST_S4;
         ST_S5:   nxt = ST_S6;
         ST_S6:   nxt = ST_S7;
         ST_S7:   nxt = ST_IDLE;
         default: nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         berr_seen <= 1'b0;
         done      <= 1'b0;
         error     <= 1'b0;
      end else begin
         state <= nxt;
         if (state == ST_S4 && (ack_s || berr_s))
            berr_seen <= berr_s;
         done  <= (state == ST_S7);
         error <= (state == ST_S7) && berr_seen;
      end
   end
endmodule

// File: rtl/hsbus_drive.sv
module hsbus_drive
   import hsbus_pkg::*;
#(
   parameter int AW = 24,
   parameter int DW = 16
) (
   input  phase_e          state,
   input  logic            wr_q,
   input  logic [1:0]      lanes_q,
   input  logic [AW-1:0]   addr_q,
   input  logic [DW-1:0]   wdata_q,
   output logic [AW-1:0]   bus_addr,
   output logic            bus_as_n,
   output logic            bus_uds_n,
   output logic            bus_lds_n,
   output logic            bus_rw,
   output logic            bus_data_oe,
   output logic [DW-1:0]   bus_data_out
);
   logic addr_on, as_on, ds_on, wr_phase, oe_phase;

   always_comb begin
      addr_on  = state inside {ST_S1, ST_S2, ST_S3, ST_S4, ST_W4, ST_S5, ST_S6, ST_S7};
      as_on    = state inside {ST_S2, ST_S3, ST_S4, ST_W4, ST_S5, ST_S6};
      wr_phase = state inside {ST_S2, ST_S3, ST_S4, ST_W4, ST_S5, ST_S6, ST_S7};
      oe_phase = state inside {ST_S3, ST_S4, ST_W4, ST_S5, ST_S6, ST_S7};
      if (wr_q) ds_on = state inside {ST_S4, ST_W4, ST_S5, ST_S6};
      else      ds_on = as_on;
   end

   assign bus_addr     = addr_on ? addr_q : '0;
   assign bus_as_n     = !as_on;
   assign bus_uds_n    = !(ds_on && lanes_q[1]);
   assign bus_lds_n    = !(ds_on && lanes_q[0]);
   assign bus_rw       = !(wr_q && wr_phase);
   assign bus_data_oe  = wr_q && oe_phase;
   assign bus_data_out = wdata_q;
endmodule

// File: rtl/hsbus_master.sv
module hsbus_master
   import hsbus_pkg::*;
#(
   parameter int AW          = 24,
   parameter int DW          = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            req_valid,
   input  logic            req_write,
   input  logic [AW-1:0]   req_addr,
   input  logic [1:0]      req_lanes,
   input  logic [DW-1:0]   req_wdata,
   output logic            idle,
   output logic            rsp_done,
   output logic            rsp_error,
   output logic [DW-1:0]   rsp_rdata,
   output logic [AW-1:0]   bus_addr,
   output logic            bus_as_n,
   output logic            bus_uds_n,
   output logic            bus_lds_n,
   output logic            bus_rw,
   output logic            bus_data_oe,
   output logic [DW-1:0]   bus_data_out,
   input  logic [DW-1:0]   bus_data_in,
   input  logic            bus_ack_n,
   input  logic            bus_berr_n
);
   localparam int HALF = DW / 2;

   generate
      if (DW < 2 || (DW % 2) != 0) begin : g_bad_dw
         $error("hsbus_master: DW must be even and at least 2");
      end
      if (AW < 1) begin : g_bad_aw
         $error("hsbus_master: AW must be at least 1");
      end
      if (HALF < 1) begin : g_bad_half
         $error("hsbus_master: lane width must be positive");
      end
   endgenerate

   phase_e          state;
   logic            accept;
   logic            ack_s, berr_s;
   logic            wr_q;
   logic [1:0]      lanes_q;
   logic [AW-1:0]   addr_q;
   logic [DW-1:0]   wdata_q;

   hsbus_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
      .clk(clk), .rst_n(rst_n), .d(!bus_ack_n), .q(ack_s)
   );

   hsbus_sync #(.STAGES(SYNC_STAGES)) u_berr_sync (
      .clk(clk), .rst_n(rst_n), .d(!bus_berr_n), .q(berr_s)
   );

   hsbus_seq u_seq (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
      .ack_s(ack_s), .berr_s(berr_s),
      .state(state), .accept(accept), .done(rsp_done), .error(rsp_error)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_q    <= 1'b0;
         lanes_q <= '0;
         addr_q  <= '0;
         wdata_q <= '0;
      end else if (accept) begin
         wr_q    <= req_write;
         lanes_q <= req_lanes;
         addr_q  <= req_addr;
         wdata_q <= req_wdata;
      end
   end

   // read data is taken on the edge that moves S6 into S7
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          rsp_rdata <= '0;
      else if (state == ST_S6 && !wr_q)    rsp_rdata <= bus_data_in;
   end

   assign idle = (state == ST_IDLE);

   hsbus_drive #(.AW(AW), .DW(DW)) u_drive (
      .state(state), .wr_q(wr_q), .lanes_q(lanes_q), .addr_q(addr_q),
      .wdata_q(wdata_q), .bus_addr(bus_addr), .bus_as_n(bus_as_n),
      .bus_uds_n(bus_uds_n), .bus_lds_n(bus_lds_n), .bus_rw(bus_rw),
      .bus_data_oe(bus_data_oe), .bus_data_out(bus_data_out)
   );
endmodule

// File: rtl/hsbus_checker.sv
module hsbus_checker
   import hsbus_pkg::*;
#(
   parameter int AW = 24
) (
   input logic          clk,
   input logic          rst_n,
   input phase_e        state,
   input logic          wr_q,
   input logic          ack_s,
   input logic          berr_s,
   input logic [AW-1:0] bus_addr,
   input logic          bus_as_n,
   input logic          bus_uds_n,
   input logic          bus_lds_n,
   input logic          bus_rw,
   input logic          bus_data_oe,
   input logic          rsp_done,
   input logic          rsp_error
);
   assert_addr_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_as_n && $past(!bus_as_n)) |-> $stable(bus_addr));

   assert_write_ds_late_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_q && (state == ST_S2 || state == ST_S3)) |-> (bus_uds_n && bus_lds_n));

   assert_oe_write_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
      bus_data_oe |-> !bus_rw);

   assert_no_early_exit_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_S4 && !ack_s && !berr_s) |=> (state == ST_W4));

   assert_wait_full_period_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_W4) |=> (state == ST_S4));

   assert_done_after_s7_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rsp_done) |-> ($past(state) == ST_S7));

   assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_done |=> !rsp_done);

   assert_error_with_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_error |-> rsp_done);

   assert_busy_no_restart_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (state != ST_IDLE && state != ST_S7) |=> (state != ST_S0));
endmodule

bind hsbus_master hsbus_checker #(.AW(AW)) i_hsbus_checker (
   .clk(clk), .rst_n(rst_n), .state(state), .wr_q(wr_q),
   .ack_s(ack_s), .berr_s(berr_s), .bus_addr(bus_addr),
   .bus_as_n(bus_as_n), .bus_uds_n(bus_uds_n), .bus_lds_n(bus_lds_n),
   .bus_rw(bus_rw), .bus_data_oe(bus_data_oe),
   .rsp_done(rsp_done), .rsp_error(rsp_error)
);

// File: tb/test_hsbus_master.sv
module test_hsbus_master;
   localparam int AW = 24;
   localparam int DW = 16;
   localparam time PERIOD = 10ns;

   typedef struct {
      bit            wr;
      logic [DW-1:0] rdata;
      bit            err;
      int            lat;
   } exp_t;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            req_valid = 1'b0;
   logic            req_write = 1'b0;
   logic [AW-1:0]   req_addr = '0;
   logic [1:0]      req_lanes = '0;
   logic [DW-1:0]   req_wdata = '0;
   logic            idle, rsp_done, rsp_error;
   logic [DW-1:0]   rsp_rdata;
   logic [AW-1:0]   bus_addr;
   logic            bus_as_n, bus_uds_n, bus_lds_n, bus_rw, bus_data_oe;
   logic [DW-1:0]   bus_data_out;
   logic [DW-1:0]   bus_data_in = '0;
   logic            bus_ack_n, bus_berr_n;

   int   n_checks = 0;
   int   n_err = 0;
   int   cyc = 0;
   int   start_cyc = 0;
   bit   finished = 0;
   exp_t exp_q[$];

   // responder controls, written by the driver only
   int   resp_d = 1;
   int   resp_kind = 0;   // 0 ack, 1 bus error, 2 both
   int   xfer_id = 0;
   bit   early_on = 0;
   // responder state, written by the responder only
   int   seen_id = 0;
   int   resp_rc = 0;
   bit   resp_active = 0;
   bit   ack_on = 0;
   bit   berr_on = 0;

   assign bus_ack_n  = !(ack_on || early_on);
   assign bus_berr_n = !berr_on;

   always #(PERIOD/2) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   hsbus_master #(.AW(AW), .DW(DW)) i_hsbus_master (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_lanes(req_lanes), .req_wdata(req_wdata),
      .idle(idle), .rsp_done(rsp_done), .rsp_error(rsp_error),
      .rsp_rdata(rsp_rdata), .bus_addr(bus_addr), .bus_as_n(bus_as_n),
      .bus_uds_n(bus_uds_n), .bus_lds_n(bus_lds_n), .bus_rw(bus_rw),
      .bus_data_oe(bus_data_oe), .bus_data_out(bus_data_out),
      .bus_data_in(bus_data_in), .bus_ack_n(bus_ack_n), .bus_berr_n(bus_berr_n)
   );

   task automatic check(input bit ok, input string rq, input logic [31:0] act,
                        input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h (t=%0t)", rq, act, exp, $time);
      end
   endtask

   // responder: counts falling edges with the address strobe low
   always @(negedge clk) begin
      if (xfer_id != seen_id) begin
         seen_id     = xfer_id;
         resp_rc     = 0;
         resp_active = 1;
      end
      if (resp_active) begin
         if (!bus_as_n) begin
            resp_rc++;
            if (resp_rc >= resp_d) begin
               ack_on  = (resp_kind != 1);
               berr_on = (resp_kind != 0);
            end
         end else if (resp_rc > 0) begin
            ack_on      = 0;
            berr_on     = 0;
            resp_active = 0;
         end
      end
   end

   // monitor: scoreboard compare on every completion
   always @(negedge clk) begin
      if (rst_n && rsp_done) begin
         if (exp_q.size() == 0) begin
            check(0, "R11 unexpected done", 1, 0);
         end else begin
            exp_t e;
            e = exp_q.pop_front();
            check((cyc - start_cyc) == e.lat, "R8 done latency", cyc - start_cyc, e.lat);
            check(rsp_error == e.err, "R10 error flag", rsp_error, e.err);
            if (!e.wr)
               check(rsp_rdata == e.rdata, "R9 read data", rsp_rdata, e.rdata);
         end
      end
   end

   task automatic xfer(input bit wr, input logic [AW-1:0] a, input logic [1:0] ln,
                       input logic [DW-1:0] wd, input logic [DW-1:0] rd,
                       input int d, input int kind, input bit early, input bit intrude);
      int   w;
      int   last;
      exp_t e;
      w    = d / 2;        // ack seen at S4 after d+3 edges from S2 timing
      last = 8 + 2 * w;
      @(negedge clk);
      req_valid   = 1; req_write = wr; req_addr = a; req_lanes = ln; req_wdata = wd;
      bus_data_in = rd;
      resp_d      = d; resp_kind = kind;
      xfer_id     = xfer_id + 1;
      e.wr = wr; e.rdata = rd; e.err = (kind != 0); e.lat = last;
      exp_q.push_back(e);
      @(posedge clk);
      for (int c = 0; c <= last; c++) begin
         @(negedge clk);
         if (c == 0) begin
            req_valid = 0;
            start_cyc = cyc;
            if (early) early_on = 1;
            check(bus_addr == '0, "R2 addr zero in S0", bus_addr, 0);
            check(bus_as_n == 1, "R3 strobe high in S0", bus_as_n, 1);
         end
         if (c == 1) begin
            early_on = 0;
            check(bus_addr == a, "R2 addr in S1", bus_addr, a);
            check(bus_as_n == 1, "R3 strobe high in S1", bus_as_n, 1);
         end
         if (intrude && c == 3) begin req_valid = 1; req_addr = ~a; end
         if (intrude && c == 4) req_valid = 0;
         if (c == 2) begin
            check(bus_as_n == 0, "R3 strobe low in S2", bus_as_n, 0);
            check({bus_uds_n, bus_lds_n} == (wr ? 2'b11 : ~ln), "R4 lanes in S2",
                  {bus_uds_n, bus_lds_n}, wr ? 2'b11 : ~ln);
            check(bus_rw == !wr, "R5 rw in S2", bus_rw, !wr);
         end
         if (c == 3) begin
            check(bus_data_oe == wr, "R6 oe in S3", bus_data_oe, wr);
            if (wr) check(bus_data_out == wd, "R6 write data", bus_data_out, wd);
         end
         if (c == 4)
            check({bus_uds_n, bus_lds_n} == ~ln, "R4 lanes in S4",
                  {bus_uds_n, bus_lds_n}, ~ln);
         if (c >= 5 && c <= last - 2) begin
            check(bus_as_n == 0, "R7 strobe held before termination", bus_as_n, 0);
            check(rsp_done == 0, "R8 no early done", rsp_done, 0);
         end
         if (c == last - 1) begin
            check(bus_as_n == 1, "R3 strobe high in S7", bus_as_n, 1);
            check({bus_uds_n, bus_lds_n} == 2'b11, "R4 lanes off in S7",
                  {bus_uds_n, bus_lds_n}, 2'b11);
            check(bus_data_oe == wr, "R6 oe in S7", bus_data_oe, wr);
            check(bus_rw == !wr, "R5 rw in S7", bus_rw, !wr);
            check(bus_addr == a, "R11 addr kept", bus_addr, a);
         end
         if (c == last) begin
            check(rsp_done == 1, "R8 done due", rsp_done, 1);
            check(bus_data_oe == 0, "R6 oe released", bus_data_oe, 0);
            check(bus_rw == 1, "R5 rw released", bus_rw, 1);
            check(bus_addr == '0, "R2 addr cleared", bus_addr, 0);
         end
      end
      @(negedge clk);
      check(rsp_done == 0, "R10 done one cycle", rsp_done, 0);
      if (intrude) begin
         for (int k = 0; k < 3; k++) begin
            check(idle == 1, "R11 stays idle", idle, 1);
            check(bus_as_n == 1, "R11 no new cycle", bus_as_n, 1);
            @(negedge clk);
         end
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check(idle == 1, "R1 idle", idle, 1);
      check({bus_as_n, bus_uds_n, bus_lds_n} == 3'b111, "R1 strobes",
            {bus_as_n, bus_uds_n, bus_lds_n}, 3'b111);
      check(bus_rw == 1 && bus_data_oe == 0, "R1 rw/oe", {bus_rw, bus_data_oe}, 2'b10);
      check(rsp_done == 0 && rsp_error == 0, "R1 response", {rsp_done, rsp_error}, 0);
      rst_n = 1;
      repeat (2) @(negedge clk);
      check(idle == 1, "R1 idle after release", idle, 1);

      xfer(0, 24'h12_3456, 2'b11, 16'h0000, 16'hBEEF, 1, 0, 0, 0); // read, no wait
      xfer(1, 24'h00_0A0A, 2'b10, 16'hC3A5, 16'h0000, 1, 0, 0, 0); // write upper
      xfer(0, 24'hFF_0001, 2'b01, 16'h0000, 16'h5A17, 4, 0, 0, 0); // read, 2 waits
      xfer(1, 24'h40_2222, 2'b11, 16'h7E81, 16'h0000, 3, 1, 0, 0); // write, bus error
      xfer(0, 24'h01_0F0F, 2'b11, 16'h0000, 16'h9001, 2, 2, 0, 0); // both inputs
      xfer(0, 24'h33_3330, 2'b10, 16'h0000, 16'h4242, 3, 0, 1, 0); // early pulse R7
      xfer(1, 24'h55_AAAA, 2'b01, 16'h1234, 16'h0000, 1, 0, 0, 1); // busy request R11

      repeat (4) @(negedge clk);
      check(exp_q.size() == 0, "R8 all completions seen", exp_q.size(), 0);
      finished = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         check(0, "R8 watchdog expired", 0, 1);
         $display("Result: errors=%0d of %0d checks", n_err, n_checks);
         $finish;
      end
   end
endmodule